// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits between a processor core and an attached coprocessor. It carries out one coprocessor instruction at a time. The five kinds are: a load into the coprocessor from memory, a store from the coprocessor to memory, a register move into the coprocessor, a register move out of it, and an internal data operation. The core starts an instruction with a single-cycle `start` pulse. The pulse carries the instruction kind, the coprocessor number, a word-aligned start address and a source word. A mask gives one permission bit per coprocessor.

The sequencer first offers a first phase. For as long as the coprocessor answers busy, it inserts one idle cycle and then offers a busy phase. During each idle cycle of that wait it looks at the pending reset, fast-interrupt and interrupt requests. If one of them is active it sends an interrupt phase, abandons the instruction and requests the matching exception. Once the coprocessor accepts, the sequencer runs the memory side of a load or store, moving successive words for as long as the coprocessor replies increment. A register move uses coprocessor cycles instead of memory.

Each instruction ends in exactly one single-cycle pulse: either `done` or one exception request.

Top module: `cp_handshake_seq`

## Requirements
- R1: A start is refused with exception code 1 (undefined), one cycle after the start, and no phase is issued, when `cp_allow[cp_num]` is 0 or the kind is outside the range 0..4. Kind codes: 0 load, 1 store, 2 move in, 3 move out, 4 data op.
- R2: The first phase (code 1) comes in the cycle after the start. Each busy reply (response code 1) is followed by one idle cycle with no phase, and then a busy phase (code 2).
- R3: In an idle cycle of the busy wait, pending requests are served in a fixed order: reset first, then an unmasked fast interrupt, then an unmasked interrupt. The sequencer issues the interrupt phase (code 3) in the next cycle, together with exception code 4, 5 or 6 respectively, and abandons the instruction.
- R4: A fast interrupt or interrupt whose mask bit is 1 has no effect; the instruction completes normally.
- R5: A cannot reply (code 2) to a first or busy phase raises exception code 1 in the next cycle.
- R6: After acceptance (reply ready 0, increment 3 or done 4), a load issues a transfer phase (code 4). Then, for each word i, it issues a read at start + 4i followed by a data phase (code 5) that carries the word read. A data-phase reply of increment continues with the next word.
- R7: After acceptance, a store issues a data phase for each word i, takes the coprocessor's word and writes it at start + 4i in the next cycle. It continues while the data-phase reply is increment.
- R8: A word address at or above 2^FAULT_BIT raises exception code 2 (internal abort) for a load or store, and so does an address below VEC_SIZE for a store. The access for that word is not made.
- R9: An external abort seen with a read or write strobe raises exception code 3 (data abort) in the next cycle and ends the instruction.
- R10: A move in ends with one coprocessor cycle that carries the source word on `cp_wdata`. A move out ends with one coprocessor cycle that captures `cp_rdata` into `mv_result`, followed by one idle cycle.
- R11: A data op completes with `done` in the cycle after the accepting reply.
- R12: `exc_valid` and `done` are never high together, each lasts one cycle, and a new start is taken only when both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction |
| op_kind | input | 3 | Instruction kind |
| cp_num | input | CPW | Coprocessor number |
| cp_allow | input | NCP | Per-coprocessor permission mask |
| base_addr | input | AW | Start address (word aligned) |
| src_data | input | DW | Word for a move in |
| cp_resp | input | 3 | Coprocessor reply to the current phase |
| cp_rdata | input | DW | Word from the coprocessor |
| reset_req | input | 1 | Pending reset |
| fiq_req | input | 1 | Pending fast interrupt |
| fiq_mask | input | 1 | Fast interrupt masked |
| irq_req | input | 1 | Pending interrupt |
| irq_mask | input | 1 | Interrupt masked |
| mem_rdata | input | DW | Read data, valid with `mem_rd` |
| mem_abort | input | 1 | External abort, valid with a strobe |
| cp_phase | output | 3 | Phase code (0 none) |
| cp_wdata | output | DW | Word to the coprocessor |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| cyc_idle | output | 1 | Idle cycle |
| cyc_cop | output | 1 | Coprocessor cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Normal completion pulse |
| exc_valid | output | 1 | Exception request pulse |
| exc_code | output | 3 | Exception code |
| mv_result | output | DW | Word captured by a move out |

## Verification
Two things can meet in a single idle cycle of the busy wait: the continuation of the handshake and the interrupt check. The same holds for several requests arriving together, which contend through the fixed priority. The bench holds reset, fast-interrupt and interrupt requests in chosen combinations of pending and masked while the scripted coprocessor replies busy. It then judges which exception code appears, in which cycle it appears, and whether any memory access followed. A second meeting point is a word address that is both out of range and at the abort location: the internal abort must win and no strobe may be issued. The bench provokes this with loads that cross the fault boundary while an abort sits on a later word.

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NCP = 16,
  parameter int VEC_SIZE = 32,
  parameter int FAULT_BIT = 26,
  localparam int CPW = $clog2(NCP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op_kind,
  input  logic [CPW-1:0] cp_num,
  input  logic [NCP-1:0] cp_allow,
  input  logic [AW-1:0]  base_addr,
  input  logic [DW-1:0]  src_data,
  input  logic [2:0]     cp_resp,
  input  logic [DW-1:0]  cp_rdata,
  input  logic           reset_req,
  input  logic           fiq_req,
  input  logic           fiq_mask,
  input  logic           irq_req,
  input  logic           irq_mask,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_abort,
  output logic [2:0]     cp_phase,
  output logic [DW-1:0]  cp_wdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           cyc_idle,
  output logic           cyc_cop,
  output logic           busy,
  output logic           done,
  output logic           exc_valid,
  output logic [2:0]     exc_code,
  output logic [DW-1:0]  mv_result
);

  localparam logic [2:0] K_LOAD = 3'd0, K_STORE = 3'd1, K_MIN = 3'd2,
                         K_MOUT = 3'd3, K_DOP = 3'd4;
  localparam logic [2:0] A_READY = 3'd0, A_BUSY = 3'd1, A_CANT = 3'd2,
                         A_INC = 3'd3;
  localparam logic [2:0] P_NONE = 3'd0, P_FIRST = 3'd1, P_BUSY = 3'd2,
                         P_INT = 3'd3, P_XFER = 3'd4, P_DATA = 3'd5;
  localparam logic [2:0] X_UNDEF = 3'd1, X_IABT = 3'd2, X_DABT = 3'd3,
                         X_RESET = 3'd4, X_FIQ = 3'd5, X_IRQ = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INT, S_XFER, S_LRD, S_LDATA,
    S_SDATA, S_SWR, S_CCYC, S_TAIL
  } state_t;

  state_t         st;
  logic [2:0]     op;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  word;
  logic           more;

  wire addr_fault = |addr[AW-1:FAULT_BIT];
  wire addr_vec   = addr < AW'(VEC_SIZE);
  wire bad_ld     = addr_fault;
  wire bad_st     = addr_fault | addr_vec;
  wire fiq_live   = fiq_req & ~fiq_mask;
  wire irq_live   = irq_req & ~irq_mask;
  wire int_pend   = reset_req | fiq_live | irq_live;
  wire [2:0] int_kind = reset_req ? X_RESET : (fiq_live ? X_FIQ : X_IRQ);
  wire take       = start && st == S_IDLE && !exc_valid && !done;
  wire ask_st     = st == S_FIRST || st == S_BUSY;

  always_comb begin
    case (st)
      S_FIRST:         cp_phase = P_FIRST;
      S_BUSY:          cp_phase = P_BUSY;
      S_INT:           cp_phase = P_INT;
      S_XFER:          cp_phase = P_XFER;
      S_LDATA, S_SDATA: cp_phase = P_DATA;
      default:         cp_phase = P_NONE;
    endcase
  end

  assign cp_wdata  = (st == S_LDATA || (st == S_CCYC && op == K_MIN)) ? word : '0;
  assign mem_rd    = st == S_LRD && !bad_ld;
  assign mem_wr    = st == S_SWR;
  assign mem_addr  = addr;
  assign mem_wdata = word;
  assign cyc_idle  = st == S_WAIT || st == S_TAIL;
  assign cyc_cop   = st == S_CCYC;
  assign busy      = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op        <= K_LOAD;
      addr      <= '0;
      word      <= '0;
      more      <= 1'b0;
      done      <= 1'b0;
      exc_valid <= 1'b0;
      exc_code  <= 3'd0;
      mv_result <= '0;
    end else begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          op   <= op_kind;
          addr <= base_addr;
          word <= src_data;
          if (!cp_allow[cp_num] || op_kind > K_DOP) begin
            exc_valid <= 1'b1;
            exc_code  <= X_UNDEF;
          end else st <= S_FIRST;
        end
        S_FIRST, S_BUSY: begin
          if (cp_resp == A_BUSY) st <= S_WAIT;
          else if (cp_resp == A_CANT) begin
            exc_valid <= 1'b1;
            exc_code  <= X_UNDEF;
            st        <= S_IDLE;
          end else begin
            case (op)
              K_LOAD:        st <= S_XFER;
              K_STORE:       st <= S_SDATA;
              K_MIN, K_MOUT: st <= S_CCYC;
              default: begin
                done <= 1'b1;
                st   <= S_IDLE;
              end
            endcase
          end
        end
        S_WAIT: begin
          if (int_pend) begin
            exc_valid <= 1'b1;
            exc_code  <= int_kind;
            st        <= S_INT;
          end else st <= S_BUSY;
        end
        S_INT:  st <= S_IDLE;
        S_XFER: st <= S_LRD;
        S_LRD: begin
          if (bad_ld || mem_abort) begin
            exc_valid <= 1'b1;
            exc_code  <= bad_ld ? X_IABT : X_DABT;
            st        <= S_IDLE;
          end else begin
            word <= mem_rdata;
            st   <= S_LDATA;
          end
        end
        S_LDATA: begin
          if (cp_resp == A_INC) begin
            addr <= addr + AW'(4);
            st   <= S_LRD;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_SDATA: begin
          if (bad_st) begin
            exc_valid <= 1'b1;
            exc_code  <= X_IABT;
            st        <= S_IDLE;
          end else begin
            word <= cp_rdata;
            more <= cp_resp == A_INC;
            st   <= S_SWR;
          end
        end
        S_SWR: begin
          if (mem_abort) begin
            exc_valid <= 1'b1;
            exc_code  <= X_DABT;
            st        <= S_IDLE;
          end else if (more) begin
            addr <= addr + AW'(4);
            st   <= S_SDATA;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_CCYC: begin
          if (op == K_MOUT) begin
            mv_result <= cp_rdata;
            st        <= S_TAIL;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_TAIL: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_deny_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (!cp_allow[cp_num] || op_kind > K_DOP)) |=>
      (exc_valid && exc_code == X_UNDEF && cp_phase == P_NONE));

  assert_busy_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ask_st && cp_resp == A_BUSY) |=> (cyc_idle && cp_phase == P_NONE));

  assert_reset_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && reset_req) |=> (exc_valid && exc_code == X_RESET && cp_phase == P_INT));

  assert_cant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ask_st && cp_resp == A_CANT) |=> (exc_valid && exc_code == X_UNDEF));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && mem_abort) |=> (exc_valid && exc_code == X_DABT && !busy));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid || done) |=> !(exc_valid || done));

  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && done));

endmodule

// File: tb/tb_cp_handshake_seq.sv
module tb_cp_handshake_seq;
  localparam int AW = 32, DW = 32, NCP = 16, CPW = 4;
  localparam int VEC_SIZE = 32, FAULT_BIT = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op_kind = '0;
  logic [CPW-1:0] cp_num = '0;
  logic [NCP-1:0] cp_allow = '1;
  logic [AW-1:0] base_addr = '0;
  logic [DW-1:0] src_data = '0;
  logic [2:0] cp_resp = '0;
  logic [DW-1:0] cp_rdata = '0;
  logic reset_req = 0, fiq_req = 0, fiq_mask = 0, irq_req = 0, irq_mask = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_abort = 0;
  logic [2:0] cp_phase;
  logic [DW-1:0] cp_wdata, mem_wdata, mv_result;
  logic mem_rd, mem_wr, cyc_idle, cyc_cop, busy, done, exc_valid;
  logic [AW-1:0] mem_addr;
  logic [2:0] exc_code;

  int n_chk = 0, n_bad = 0;

  cp_handshake_seq #(.AW(AW), .DW(DW), .NCP(NCP), .VEC_SIZE(VEC_SIZE), .FAULT_BIT(FAULT_BIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .cp_num(cp_num),
    .cp_allow(cp_allow), .base_addr(base_addr), .src_data(src_data), .cp_resp(cp_resp),
    .cp_rdata(cp_rdata), .reset_req(reset_req), .fiq_req(fiq_req), .fiq_mask(fiq_mask),
    .irq_req(irq_req), .irq_mask(irq_mask), .mem_rdata(mem_rdata), .mem_abort(mem_abort),
    .cp_phase(cp_phase), .cp_wdata(cp_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cyc_idle(cyc_idle), .cyc_cop(cyc_cop),
    .busy(busy), .done(done), .exc_valid(exc_valid), .exc_code(exc_code), .mv_result(mv_result));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction

  function automatic bit is_fault(input logic [31:0] a);
    return |a[31:FAULT_BIT];
  endfunction

  function automatic bit is_vec(input logic [31:0] a);
    return a < VEC_SIZE;
  endfunction

  task automatic run(input string req, input int op, input bit allow, input logic [31:0] base,
                     input int k, input bit cant, input int n, input int abort_j,
                     input bit rq, input bit fq, input bit fm, input bit iq, input bit im);
    logic [2:0] script[16];
    int sidx = 0, nd = 0, n_rd = 0, n_wr = 0, n_idle = 0, n_cop = 0, n_int = 0, errs = 0;
    int lat = 0, jb, e_lat, e_rd = 0, e_wr = 0, e_idle, e_cop = 0;
    logic [2:0] e_code = 0, got_code = 0;
    bit got_done = 0, e_done = 0;
    logic [15:0] tag = 16'($urandom);
    logic [31:0] src = $urandom;
    for (int i = 0; i < 16; i++) script[i] = 3'd4;
    for (int i = 0; i < k; i++) script[i] = 3'd1;
    script[k] = cant ? 3'd2 : 3'd0;
    for (int i = 0; i < n; i++) script[k + 1 + i] = (i < n - 1) ? 3'd3 : 3'd4;
    e_idle = k;
    if (!allow || op > 4) begin e_code = 1; e_lat = 1; e_idle = 0; end
    else if (k > 0 && (rq || (fq && !fm) || (iq && !im))) begin
      e_code = rq ? 3'd4 : ((fq && !fm) ? 3'd5 : 3'd6); e_lat = 3; e_idle = 1;
    end else if (cant) begin e_code = 1; e_lat = 2 + 2*k; end
    else if (op == 4) begin e_done = 1; e_lat = 2 + 2*k; end
    else if (op == 2) begin e_done = 1; e_lat = 3 + 2*k; e_cop = 1; end
    else if (op == 3) begin e_done = 1; e_lat = 4 + 2*k; e_cop = 1; e_idle = k + 1; end
    else begin
      jb = n;
      for (int i = n - 1; i >= 0; i--)
        if (is_fault(base + 4*i) || (op == 1 && is_vec(base + 4*i))) jb = i;
      if (jb < n && (abort_j < 0 || jb <= abort_j)) begin
        e_code = 2;
        if (op == 0) begin e_lat = 4 + 2*k + 2*jb; e_rd = jb; end
        else begin e_lat = 3 + 2*k + 2*jb; e_wr = jb; end
      end else if (abort_j >= 0 && abort_j < n) begin
        e_code = 3; e_lat = 4 + 2*k + 2*abort_j;
        if (op == 0) e_rd = abort_j + 1; else e_wr = abort_j + 1;
      end else begin
        e_done = 1;
        if (op == 0) begin e_lat = 3 + 2*k + 2*n; e_rd = n; end
        else begin e_lat = 2 + 2*k + 2*n; e_wr = n; end
      end
    end
    reset_req = rq; fiq_req = fq; fiq_mask = fm; irq_req = iq; irq_mask = im;
    op_kind = 3'(op); cp_num = 4'($urandom); base_addr = base; src_data = src;
    cp_allow = '1; cp_allow[cp_num] = allow;
    start = 1'b1;
    for (int c = 1; c <= 100; c++) begin
      @(negedge clk);
      start = 1'b0;
      mem_abort = 1'b0;
      cp_rdata = {tag, 16'h0};
      if (cp_phase == 3'd1 || cp_phase == 3'd2 || cp_phase == 3'd5) begin
        cp_resp = script[sidx];
        sidx++;
      end
      if (cp_phase == 3'd5) begin
        cp_rdata = {tag, 16'(nd)};
        if (op == 0 && cp_wdata !== memf(base + 4*nd)) errs++;
        nd++;
      end
      if (cp_phase == 3'd3) n_int++;
      if (cyc_idle) n_idle++;
      if (cyc_cop) begin
        n_cop++;
        if (op == 2 && cp_wdata !== src) errs++;
      end
      if (mem_rd) begin
        if (mem_addr !== base + 4*n_rd) errs++;
        mem_rdata = memf(mem_addr);
        mem_abort = abort_j >= 0 && mem_addr == base + 4*abort_j;
        n_rd++;
      end
      if (mem_wr) begin
        if (mem_addr !== base + 4*n_wr || mem_wdata !== {tag, 16'(n_wr)}) errs++;
        mem_abort = abort_j >= 0 && mem_addr == base + 4*abort_j;
        n_wr++;
      end
      if (exc_valid || done) begin
        lat = c; got_code = exc_valid ? exc_code : 3'd0; got_done = done;
        break;
      end
    end
    check({req, " code"}, 32'(got_code), 32'(e_code));
    check({req, " done"}, 32'(got_done), 32'(e_done));
    check({req, " latency"}, 32'(lat), 32'(e_lat));
    check({req, " reads"}, 32'(n_rd), 32'(e_rd));
    check({req, " writes"}, 32'(n_wr), 32'(e_wr));
    check({req, " idle"}, 32'(n_idle), 32'(e_idle));
    check({req, " cop"}, 32'(n_cop), 32'(e_cop));
    check({req, " addr/data"}, 32'(errs), 32'd0);
    check({req, " int phase"}, 32'(n_int), 32'(e_code >= 4));
    if (op == 3 && e_done) check("R10 move out result", mv_result, {tag, 16'h0});
    @(negedge clk);
    check({req, " end pulse single"}, 32'(exc_valid | done), 32'd0);
    reset_req = 0; fiq_req = 0; irq_req = 0; mem_abort = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R12 reset busy", 32'(busy), 0);
    check("R12 reset pulses", 32'({exc_valid, done, mem_rd, mem_wr}), 0);
    check("R2 reset phase", 32'(cp_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run("R1 denied", 0, 0, 32'h400, 0, 0, 1, -1, 0, 0, 0, 0, 0);
    run("R1 bad kind", 6, 1, 32'h400, 0, 0, 1, -1, 0, 0, 0, 0, 0);
    run("R5 cannot", 4, 1, 32'h400, 2, 1, 1, -1, 0, 0, 0, 0, 0);
    run("R3 reset wins", 0, 1, 32'h400, 1, 0, 2, -1, 1, 1, 0, 1, 0);
    run("R3 fiq over irq", 1, 1, 32'h400, 2, 0, 2, -1, 0, 1, 0, 1, 0);
    run("R3 irq when fiq masked", 2, 1, 32'h400, 1, 0, 1, -1, 0, 1, 1, 1, 0);
    run("R4 masked ignored", 0, 1, 32'h800, 2, 0, 3, -1, 0, 1, 1, 1, 1);
    run("R2 busy wait load", 0, 1, 32'h1000, 3, 0, 4, -1, 0, 0, 0, 0, 0);
    run("R6 load", 0, 1, 32'h2000, 0, 0, 4, -1, 0, 0, 0, 0, 0);
    run("R7 store", 1, 1, 32'h3000, 1, 0, 3, -1, 0, 0, 0, 0, 0);
    run("R8 store vector", 1, 1, 32'h10, 0, 0, 2, -1, 0, 0, 0, 0, 0);
    run("R8 load vector ok", 0, 1, 32'h10, 0, 0, 2, -1, 0, 0, 0, 0, 0);
    run("R8 load crossing fault", 0, 1, 32'h03FF_FFF8, 0, 0, 4, 3, 0, 0, 0, 0, 0);
    run("R8 store crossing fault", 1, 1, 32'h03FF_FFFC, 1, 0, 3, -1, 0, 0, 0, 0, 0);
    run("R9 load abort", 0, 1, 32'h4000, 0, 0, 4, 1, 0, 0, 0, 0, 0);
    run("R9 store abort", 1, 1, 32'h5000, 2, 0, 4, 2, 0, 0, 0, 0, 0);
    run("R10 move in", 2, 1, 32'h0, 1, 0, 1, -1, 0, 0, 0, 0, 0);
    run("R10 move out", 3, 1, 32'h0, 2, 0, 1, -1, 0, 0, 0, 0, 0);
    run("R11 data op", 4, 1, 32'h0, 0, 0, 1, -1, 0, 0, 0, 0, 0);
    for (int t = 0; t < 200; t++) begin
      int op = ($urandom % 16 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      int n = 1 + $urandom % 4;
      int k = $urandom % 4;
      logic [31:0] base = {6'd0, 24'($urandom), 2'b00};
      if ($urandom % 8 == 0) base = {27'd0, 3'($urandom), 2'b00};
      if ($urandom % 8 == 0) base = 32'h0400_0000 - 32'(4 * ($urandom % 4));
      run("R12 random", op, ($urandom % 12) != 0, base, k, ($urandom % 8) == 0, n,
          ($urandom % 4 == 0) ? int'($urandom % n) : -1,
          ($urandom % 10) == 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule